// File: doc/BRIEF.md
# Per-Unit Instruction Schedule Queue

This block sits between the scoreboard check and the execute stage for one execution resource. Candidate wavefront instructions arrive on an enqueue port carrying an instruction tag, a wavefront age id and a scalar flag. An instruction is only accepted when the register-file models grant its source reads. At acceptance the block starts those reads, and the entry waits in a busy state until every read it needs has reported completion.

Each cycle the queue is scanned from head to tail. The first entry whose reads are finished is moved into a one-deep dispatch slot, provided the execution resource reports ready and the slot is empty. Execute empties the slot, or marks it skipped. An instruction that failed to dispatch downstream can be handed back through a re-insert port. It then re-enters already operand-ready, placed among the queued entries by wavefront age rather than at the tail.

Top module: `sched_queue`

## Requirements
- R1: An enqueue request is refused when the scalar register file does not grant, or when the instruction is non-scalar and the vector register file does not grant. A refused request is never queued, and `rf_stall` pulses high in the cycle after the request. A scalar instruction ignores `vrf_grant`.
- R2: An accepted enqueue raises `enq_ack` and `rd_start_sca` in the following cycle, with `rd_tag` equal to the instruction tag. `rd_start_vec` is also raised only when the instruction is non-scalar.
- R3: The queue holds DEPTH entries (default 8). An enqueue is refused with `enq_ack` low when the queue is full, and also when a re-insert is requested in the same cycle. A re-insert is refused with `reins_ack` low when the queue is full.
- R4: A newly accepted entry is busy and cannot be dispatched. It becomes dispatchable once its scalar read has completed and, for a non-scalar entry, its vector read has also completed. Completions are matched by tag on `sdone_*` and `vdone_*`. A completion in the same cycle as the scan counts for that scan.
- R5: The scan picks the entry closest to the head among the dispatchable entries, whatever their ages. Busy entries ahead of it are passed over. At most one entry leaves the queue per cycle.
- R6: An entry is moved to the slot only in a cycle when `res_rdy` is high and the slot status is EMPTY at the start of that cycle. The slot then shows the entry after that clock edge.
- R7: The slot status is encoded EMPTY=0, EXREADY=1, SKIP=2. `ex_take` sets EMPTY. `ex_skip` changes EXREADY to SKIP. Otherwise the slot status and contents are held.
- R8: A re-inserted entry is placed before the first queued entry whose age id is greater than or equal to its own, or at the tail if there is none. It is dispatchable immediately.
- R9: After reset the queue is empty, the slot is EMPTY and all pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Enqueue request |
| enq_tag | input | TAG_W | Instruction tag of the request |
| enq_age | input | AGE_W | Wavefront age id of the request |
| enq_scalar | input | 1 | Request is a scalar instruction |
| vrf_grant | input | 1 | Vector register file can schedule the reads |
| srf_grant | input | 1 | Scalar register file can schedule the reads |
| enq_ack | output | 1 | Previous-cycle enqueue accepted |
| rf_stall | output | 1 | Previous-cycle enqueue denied register-file access |
| rd_start_vec | output | 1 | Vector operand read started |
| rd_start_sca | output | 1 | Scalar operand read started |
| rd_tag | output | TAG_W | Tag of the instruction whose reads started |
| vdone_valid | input | 1 | Vector read completion |
| vdone_tag | input | TAG_W | Tag of the completed vector read |
| sdone_valid | input | 1 | Scalar read completion |
| sdone_tag | input | TAG_W | Tag of the completed scalar read |
| reins_valid | input | 1 | Re-insert request |
| reins_tag | input | TAG_W | Tag of the re-inserted instruction |
| reins_age | input | AGE_W | Age id of the re-inserted instruction |
| reins_scalar | input | 1 | Re-inserted instruction is scalar |
| reins_ack | output | 1 | Previous-cycle re-insert accepted |
| res_rdy | input | 1 | Execution resource ready |
| ex_take | input | 1 | Execute consumed the slot |
| ex_skip | input | 1 | Execute skipped the slot |
| slot_st | output | 2 | Slot status (0 EMPTY, 1 EXREADY, 2 SKIP) |
| slot_tag | output | TAG_W | Tag in the slot |
| slot_age | output | AGE_W | Age id in the slot |
| slot_scalar | output | 1 | Scalar flag in the slot |

## Verification
Some properties are checked on every cycle. The occupancy never exceeds DEPTH and changes by at most one entry per cycle. A register-file denial always yields a stall pulse and no acknowledge. A vector read start always comes with a scalar read start. The slot cannot fill while the resource is not ready, and an occupied slot keeps its tag until execute takes it. Other behaviours depend on the history of particular entries, so only the directed scenarios can show them. These are that a busy entry is never dispatched even when it sits at the head, that the head-most ready entry is chosen over younger ones behind it, that re-inserted entries land at the correct age position (ties included), and that refused instructions never appear in the slot.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic [1:0] {
    SLOT_EMPTY   = 2'd0,
    SLOT_EXREADY = 2'd1,
    SLOT_SKIP    = 2'd2
  } slot_st_e;
endpackage

// File: rtl/sq_admit.sv
module sq_admit (
  input  logic enq_valid,
  input  logic enq_scalar,
  input  logic vrf_grant,
  input  logic srf_grant,
  input  logic full,
  input  logic reins_valid,
  output logic enq_take,
  output logic reins_take,
  output logic rf_deny
);
  logic rf_ok;

  always_comb begin
    // scalar work needs only the scalar file; vector work needs both
    rf_ok      = srf_grant && (enq_scalar || vrf_grant);
    rf_deny    = enq_valid && !rf_ok;
    reins_take = reins_valid && !full;
    enq_take   = enq_valid && rf_ok && !full && !reins_valid;
  end
endmodule

// File: rtl/sq_pick.sv
module sq_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/sq_store.sv
module sq_store #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 6,
  parameter int AGE_W = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vdone_valid,
  input  logic [TAG_W-1:0] vdone_tag,
  input  logic             sdone_valid,
  input  logic [TAG_W-1:0] sdone_tag,
  input  logic             rm_en,
  input  logic [IDX_W-1:0] rm_idx,
  input  logic             ins_en,
  input  logic             ins_sorted,
  input  logic             ins_vpend,
  input  logic             ins_spend,
  input  logic [TAG_W-1:0] ins_tag,
  input  logic [AGE_W-1:0] ins_age,
  input  logic             ins_scalar,
  output logic [DEPTH-1:0] rdy,
  output logic [TAG_W-1:0] tag_o [DEPTH],
  output logic [AGE_W-1:0] age_o [DEPTH],
  output logic             sc_o  [DEPTH],
  output logic [CNT_W-1:0] count_o,
  output logic             full_o
);
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [AGE_W-1:0] age_q [DEPTH];
  logic             sc_q  [DEPTH];
  logic             vp_q  [DEPTH];
  logic             sp_q  [DEPTH];
  logic [CNT_W-1:0] cnt_q;

  logic             vp_c  [DEPTH];
  logic             sp_c  [DEPTH];

  logic [TAG_W-1:0] a_tag [DEPTH];
  logic [AGE_W-1:0] a_age [DEPTH];
  logic             a_sc  [DEPTH];
  logic             a_vp  [DEPTH];
  logic             a_sp  [DEPTH];
  logic [CNT_W-1:0] cnt_r;
  logic [CNT_W-1:0] pos;

  logic [TAG_W-1:0] n_tag [DEPTH];
  logic [AGE_W-1:0] n_age [DEPTH];
  logic             n_sc  [DEPTH];
  logic             n_vp  [DEPTH];
  logic             n_sp  [DEPTH];

  // completion updates land before the scan sees the entries
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      vp_c[i] = vp_q[i] && !(vdone_valid && tag_q[i] == vdone_tag);
      sp_c[i] = sp_q[i] && !(sdone_valid && tag_q[i] == sdone_tag);
      rdy[i]  = (CNT_W'(i) < cnt_q) && !vp_c[i] && !sp_c[i];
      tag_o[i] = tag_q[i];
      age_o[i] = age_q[i];
      sc_o[i]  = sc_q[i];
    end
  end

  // close the gap left by the dispatched entry
  always_comb begin
    for (int i = 0; i < DEPTH - 1; i++) begin
      if (rm_en && IDX_W'(i) >= rm_idx) begin
        a_tag[i] = tag_q[i+1];
        a_age[i] = age_q[i+1];
        a_sc[i]  = sc_q[i+1];
        a_vp[i]  = vp_c[i+1];
        a_sp[i]  = sp_c[i+1];
      end else begin
        a_tag[i] = tag_q[i];
        a_age[i] = age_q[i];
        a_sc[i]  = sc_q[i];
        a_vp[i]  = vp_c[i];
        a_sp[i]  = sp_c[i];
      end
    end
    a_tag[DEPTH-1] = tag_q[DEPTH-1];
    a_age[DEPTH-1] = age_q[DEPTH-1];
    a_sc[DEPTH-1]  = sc_q[DEPTH-1];
    a_vp[DEPTH-1]  = vp_c[DEPTH-1];
    a_sp[DEPTH-1]  = sp_c[DEPTH-1];
    cnt_r = cnt_q - CNT_W'(rm_en);
  end

  // insertion point: tail, or before the first entry not younger
  always_comb begin
    pos = cnt_r;
    if (ins_sorted) begin
      for (int i = DEPTH - 1; i >= 0; i--) begin
        if (CNT_W'(i) < cnt_r && a_age[i] >= ins_age) pos = CNT_W'(i);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      n_tag[i] = a_tag[i];
      n_age[i] = a_age[i];
      n_sc[i]  = a_sc[i];
      n_vp[i]  = a_vp[i];
      n_sp[i]  = a_sp[i];
    end
    if (ins_en) begin
      for (int i = 1; i < DEPTH; i++) begin
        if (CNT_W'(i) > pos) begin
          n_tag[i] = a_tag[i-1];
          n_age[i] = a_age[i-1];
          n_sc[i]  = a_sc[i-1];
          n_vp[i]  = a_vp[i-1];
          n_sp[i]  = a_sp[i-1];
        end
      end
      for (int i = 0; i < DEPTH; i++) begin
        if (CNT_W'(i) == pos) begin
          n_tag[i] = ins_tag;
          n_age[i] = ins_age;
          n_sc[i]  = ins_scalar;
          n_vp[i]  = ins_vpend;
          n_sp[i]  = ins_spend;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        vp_q[i] <= 1'b0;
        sp_q[i] <= 1'b0;
      end
    end else begin
      cnt_q <= cnt_r + CNT_W'(ins_en);
      for (int i = 0; i < DEPTH; i++) begin
        vp_q[i] <= n_vp[i];
        sp_q[i] <= n_sp[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      tag_q[i] <= n_tag[i];
      age_q[i] <= n_age[i];
      sc_q[i]  <= n_sc[i];
    end
  end

  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/sched_queue.sv
module sched_queue #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 6,
  parameter int AGE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enq_valid,
  input  logic [TAG_W-1:0] enq_tag,
  input  logic [AGE_W-1:0] enq_age,
  input  logic             enq_scalar,
  input  logic             vrf_grant,
  input  logic             srf_grant,
  output logic             enq_ack,
  output logic             rf_stall,
  output logic             rd_start_vec,
  output logic             rd_start_sca,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             vdone_valid,
  input  logic [TAG_W-1:0] vdone_tag,
  input  logic             sdone_valid,
  input  logic [TAG_W-1:0] sdone_tag,
  input  logic             reins_valid,
  input  logic [TAG_W-1:0] reins_tag,
  input  logic [AGE_W-1:0] reins_age,
  input  logic             reins_scalar,
  output logic             reins_ack,
  input  logic             res_rdy,
  input  logic             ex_take,
  input  logic             ex_skip,
  output logic [1:0]       slot_st,
  output logic [TAG_W-1:0] slot_tag,
  output logic [AGE_W-1:0] slot_age,
  output logic             slot_scalar
);
  import sq_pkg::*;

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             q_full;
  logic [CNT_W-1:0] q_count;
  logic [DEPTH-1:0] q_rdy;
  logic [TAG_W-1:0] q_tag [DEPTH];
  logic [AGE_W-1:0] q_age [DEPTH];
  logic             q_sc  [DEPTH];

  logic             enq_take, reins_take, rf_deny;
  logic             pick_hit, fire;
  logic [IDX_W-1:0] pick_idx;

  logic             ins_en, ins_vpend, ins_spend, ins_scalar;
  logic [TAG_W-1:0] ins_tag;
  logic [AGE_W-1:0] ins_age;

  slot_st_e         slot_q;

  sq_admit u_admit (
    .enq_valid   (enq_valid),
    .enq_scalar  (enq_scalar),
    .vrf_grant   (vrf_grant),
    .srf_grant   (srf_grant),
    .full        (q_full),
    .reins_valid (reins_valid),
    .enq_take    (enq_take),
    .reins_take  (reins_take),
    .rf_deny     (rf_deny)
  );

  always_comb begin
    ins_en = enq_take || reins_take;
    if (reins_take) begin
      ins_tag    = reins_tag;
      ins_age    = reins_age;
      ins_scalar = reins_scalar;
      ins_vpend  = 1'b0;
      ins_spend  = 1'b0;
    end else begin
      ins_tag    = enq_tag;
      ins_age    = enq_age;
      ins_scalar = enq_scalar;
      ins_vpend  = !enq_scalar;
      ins_spend  = 1'b1;
    end
  end

  sq_store #(.DEPTH(DEPTH), .TAG_W(TAG_W), .AGE_W(AGE_W)) u_store (
    .clk         (clk),
    .rst         (rst),
    .vdone_valid (vdone_valid),
    .vdone_tag   (vdone_tag),
    .sdone_valid (sdone_valid),
    .sdone_tag   (sdone_tag),
    .rm_en       (fire),
    .rm_idx      (pick_idx),
    .ins_en      (ins_en),
    .ins_sorted  (reins_take),
    .ins_vpend   (ins_vpend),
    .ins_spend   (ins_spend),
    .ins_tag     (ins_tag),
    .ins_age     (ins_age),
    .ins_scalar  (ins_scalar),
    .rdy         (q_rdy),
    .tag_o       (q_tag),
    .age_o       (q_age),
    .sc_o        (q_sc),
    .count_o     (q_count),
    .full_o      (q_full)
  );

  sq_pick #(.N(DEPTH)) u_pick (
    .req (q_rdy),
    .hit (pick_hit),
    .idx (pick_idx)
  );

  assign fire = pick_hit && res_rdy && (slot_q == SLOT_EMPTY);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q       <= SLOT_EMPTY;
      slot_tag     <= '0;
      slot_age     <= '0;
      slot_scalar  <= 1'b0;
      enq_ack      <= 1'b0;
      reins_ack    <= 1'b0;
      rf_stall     <= 1'b0;
      rd_start_vec <= 1'b0;
      rd_start_sca <= 1'b0;
      rd_tag       <= '0;
    end else begin
      enq_ack      <= enq_take;
      reins_ack    <= reins_take;
      rf_stall     <= rf_deny;
      rd_start_sca <= enq_take;
      rd_start_vec <= enq_take && !enq_scalar;
      if (enq_take) rd_tag <= enq_tag;
      if (fire) begin
        slot_q      <= SLOT_EXREADY;
        slot_tag    <= q_tag[pick_idx];
        slot_age    <= q_age[pick_idx];
        slot_scalar <= q_sc[pick_idx];
      end else if (ex_take) begin
        slot_q <= SLOT_EMPTY;
      end else if (ex_skip && slot_q == SLOT_EXREADY) begin
        slot_q <= SLOT_SKIP;
      end
    end
  end

  assign slot_st = slot_q;
endmodule

// File: rtl/sq_chk.sv
module sq_chk #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 6,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             enq_valid,
  input logic             enq_scalar,
  input logic             vrf_grant,
  input logic             srf_grant,
  input logic             enq_ack,
  input logic             rf_stall,
  input logic             rd_start_vec,
  input logic             rd_start_sca,
  input logic             res_rdy,
  input logic             ex_take,
  input logic [1:0]       slot_st,
  input logic [TAG_W-1:0] slot_tag,
  input logic [CNT_W-1:0] count
);
  assert_cap_R3: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  assert_step_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((count + 1'b1) >= $past(count)) && (count <= ($past(count) + 1'b1)));

  assert_sdeny_R1: assert property (@(posedge clk) disable iff (rst)
    (enq_valid && !srf_grant) |=> (rf_stall && !enq_ack));

  assert_vdeny_R1: assert property (@(posedge clk) disable iff (rst)
    (enq_valid && !enq_scalar && !vrf_grant) |=> (rf_stall && !enq_ack));

  assert_reads_R2: assert property (@(posedge clk) disable iff (rst)
    rd_start_vec |-> rd_start_sca);

  assert_res_R6: assert property (@(posedge clk) disable iff (rst)
    (slot_st == 2'd0 && !res_rdy) |=> (slot_st == 2'd0));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (slot_st != 2'd0 && !ex_take) |=> (slot_st != 2'd0 && $stable(slot_tag)));

  assert_take_R7: assert property (@(posedge clk) disable iff (rst)
    (slot_st != 2'd0 && ex_take) |=> (slot_st == 2'd0));
endmodule

bind sched_queue sq_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .enq_valid    (enq_valid),
  .enq_scalar   (enq_scalar),
  .vrf_grant    (vrf_grant),
  .srf_grant    (srf_grant),
  .enq_ack      (enq_ack),
  .rf_stall     (rf_stall),
  .rd_start_vec (rd_start_vec),
  .rd_start_sca (rd_start_sca),
  .res_rdy      (res_rdy),
  .ex_take      (ex_take),
  .slot_st      (slot_st),
  .slot_tag     (slot_tag),
  .count        (q_count)
);

// File: tb/sched_queue_test.sv
module sched_queue_test;
  localparam int TAG_W = 6;
  localparam int AGE_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             enq_valid = 1'b0, enq_scalar = 1'b0;
  logic [TAG_W-1:0] enq_tag = '0;
  logic [AGE_W-1:0] enq_age = '0;
  logic             vrf_grant = 1'b0, srf_grant = 1'b0;
  logic             enq_ack, rf_stall, rd_start_vec, rd_start_sca;
  logic [TAG_W-1:0] rd_tag;
  logic             vdone_valid = 1'b0, sdone_valid = 1'b0;
  logic [TAG_W-1:0] vdone_tag = '0, sdone_tag = '0;
  logic             reins_valid = 1'b0, reins_scalar = 1'b0;
  logic [TAG_W-1:0] reins_tag = '0;
  logic [AGE_W-1:0] reins_age = '0;
  logic             reins_ack;
  logic             res_rdy = 1'b0, ex_take = 1'b0, ex_skip = 1'b0;
  logic [1:0]       slot_st;
  logic [TAG_W-1:0] slot_tag;
  logic [AGE_W-1:0] slot_age;
  logic             slot_scalar;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sched_queue #(.DEPTH(8), .TAG_W(TAG_W), .AGE_W(AGE_W)) uut (
    .clk(clk), .rst(rst),
    .enq_valid(enq_valid), .enq_tag(enq_tag), .enq_age(enq_age), .enq_scalar(enq_scalar),
    .vrf_grant(vrf_grant), .srf_grant(srf_grant),
    .enq_ack(enq_ack), .rf_stall(rf_stall),
    .rd_start_vec(rd_start_vec), .rd_start_sca(rd_start_sca), .rd_tag(rd_tag),
    .vdone_valid(vdone_valid), .vdone_tag(vdone_tag),
    .sdone_valid(sdone_valid), .sdone_tag(sdone_tag),
    .reins_valid(reins_valid), .reins_tag(reins_tag), .reins_age(reins_age),
    .reins_scalar(reins_scalar), .reins_ack(reins_ack),
    .res_rdy(res_rdy), .ex_take(ex_take), .ex_skip(ex_skip),
    .slot_st(slot_st), .slot_tag(slot_tag), .slot_age(slot_age), .slot_scalar(slot_scalar)
  );

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    enq_valid = 0; vdone_valid = 0; sdone_valid = 0; reins_valid = 0;
    res_rdy = 0; ex_take = 0; ex_skip = 0; vrf_grant = 0; srf_grant = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic enq(int tag, int age, bit sc, bit vg, bit sg);
    enq_valid = 1; enq_tag = TAG_W'(tag); enq_age = AGE_W'(age); enq_scalar = sc;
    vrf_grant = vg; srf_grant = sg;
    step();
    enq_valid = 0; vrf_grant = 0; srf_grant = 0;
  endtask

  task automatic vdone(int tag);
    vdone_valid = 1; vdone_tag = TAG_W'(tag);
    step();
    vdone_valid = 0;
  endtask

  task automatic sdone(int tag);
    sdone_valid = 1; sdone_tag = TAG_W'(tag);
    step();
    sdone_valid = 0;
  endtask

  task automatic reins(int tag, int age);
    reins_valid = 1; reins_tag = TAG_W'(tag); reins_age = AGE_W'(age); reins_scalar = 1;
    step();
    reins_valid = 0;
  endtask

  task automatic take();
    ex_take = 1;
    step();
    ex_take = 0;
  endtask

  task automatic test_reset();
    do_reset();
    chk("R9", "slot status", slot_st, 0);
    chk("R9", "enq_ack", enq_ack, 0);
    chk("R9", "rf_stall", rf_stall, 0);
    chk("R9", "read starts", {rd_start_vec, rd_start_sca}, 0);
    res_rdy = 1;
    repeat (3) step();
    chk("R9", "empty queue dispatches nothing", slot_st, 0);
  endtask

  task automatic test_admit();
    do_reset();
    enq(1, 4, 0, 0, 1);
    chk("R1", "vector w/o vrf grant ack", enq_ack, 0);
    chk("R1", "vector w/o vrf grant stall", rf_stall, 1);
    enq(2, 4, 0, 1, 0);
    chk("R1", "no srf grant stall", rf_stall, 1);
    chk("R1", "no srf grant ack", enq_ack, 0);
    enq(3, 4, 1, 0, 1);
    chk("R1", "scalar ignores vrf grant", enq_ack, 1);
    chk("R1", "scalar accepted no stall", rf_stall, 0);
    chk("R2", "scalar read start", rd_start_sca, 1);
    chk("R2", "no vector read for scalar", rd_start_vec, 0);
    chk("R2", "read tag", rd_tag, 3);
    enq(4, 5, 0, 1, 1);
    chk("R2", "vector read start", rd_start_vec, 1);
    chk("R2", "vector entry scalar read", rd_start_sca, 1);
    chk("R2", "read tag vector", rd_tag, 4);
    sdone(3);
    res_rdy = 1;
    step();
    chk("R1", "first dispatched is tag 3", slot_tag, 3);
    take();
    vdone(1);
    sdone(1);
    chk("R1", "refused tag never queued", slot_st, 0);
  endtask

  task automatic test_busy();
    do_reset();
    res_rdy = 1;
    enq(10, 1, 1, 0, 1);
    enq(11, 2, 0, 1, 1);
    step(); step();
    chk("R4", "busy entries hold", slot_st, 0);
    vdone(11);
    chk("R4", "vector done alone not enough", slot_st, 0);
    sdone(11);
    chk("R4", "same-cycle completion dispatches", slot_st, 1);
    chk("R4", "busy head passed over", slot_tag, 11);
    take();
    step();
    chk("R4", "busy scalar entry held", slot_st, 0);
    sdone(10);
    chk("R4", "scalar entry after sdone", slot_tag, 10);
    chk("R4", "scalar entry slot status", slot_st, 1);
  endtask

  task automatic test_order();
    do_reset();
    enq(20, 7, 1, 0, 1);
    enq(21, 3, 1, 0, 1);
    enq(22, 9, 1, 0, 1);
    sdone(22); sdone(20); sdone(21);
    step();
    chk("R6", "no dispatch without res_rdy", slot_st, 0);
    res_rdy = 1;
    step();
    chk("R5", "head ready entry first", slot_tag, 20);
    chk("R6", "slot filled", slot_st, 1);
    step(); step();
    chk("R7", "slot held while occupied", slot_tag, 20);
    ex_skip = 1;
    step();
    ex_skip = 0;
    chk("R7", "skip status", slot_st, 2);
    step();
    chk("R7", "skip held", slot_st, 2);
    take();
    chk("R7", "take empties slot", slot_st, 0);
    step();
    chk("R5", "second in queue order", slot_tag, 21);
    take(); step();
    chk("R5", "third in queue order", slot_tag, 22);
  endtask

  task automatic test_reins();
    int exp_seq[5] = '{30, 33, 34, 31, 32};
    do_reset();
    enq(30, 2, 1, 0, 1);
    enq(31, 6, 1, 0, 1);
    enq(32, 9, 1, 0, 1);
    sdone(30); sdone(31); sdone(32);
    reins(33, 5);
    chk("R8", "reinsert accepted", reins_ack, 1);
    reins(34, 6);
    chk("R8", "tie reinsert accepted", reins_ack, 1);
    res_rdy = 1;
    step();
    for (int k = 0; k < 5; k++) begin
      chk("R8", $sformatf("age order position %0d", k), slot_tag, exp_seq[k]);
      take(); step();
    end
  endtask

  task automatic test_full();
    do_reset();
    for (int k = 0; k < 8; k++) begin
      enq(40 + k, k, 1, 0, 1);
      chk("R3", $sformatf("fill entry %0d", k), enq_ack, 1);
    end
    enq(60, 9, 1, 0, 1);
    chk("R3", "enqueue refused when full", enq_ack, 0);
    chk("R3", "full refusal is not rf stall", rf_stall, 0);
    reins(61, 0);
    chk("R3", "reinsert refused when full", reins_ack, 0);
    sdone(40);
    res_rdy = 1;
    step();
    res_rdy = 0;
    chk("R3", "head dispatched", slot_tag, 40);
    enq_valid = 1; enq_tag = 62; enq_age = 9; enq_scalar = 1; srf_grant = 1;
    reins_valid = 1; reins_tag = 63; reins_age = 0; reins_scalar = 1;
    step();
    enq_valid = 0; srf_grant = 0; reins_valid = 0;
    chk("R3", "enqueue yields to reinsert", enq_ack, 0);
    chk("R8", "reinsert taken", reins_ack, 1);
    res_rdy = 1;
    take(); step();
    chk("R8", "reinserted at head by age", slot_tag, 63);
  endtask

  initial begin
    test_reset();
    test_admit();
    test_busy();
    test_order();
    test_reins();
    test_full();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule